// File: doc/BRIEF.md
# Four-Channel Memory-Mapped Interval Timer

The block holds four independent 32-bit up-counters behind a simple register bus. The bus has an address, a write strobe, write data and a combinational read-data return. Each channel steps only on its own tick-enable input. The slow, millisecond and microsecond rates are made outside the block and reach it as single-cycle tick pulses. By convention channel 0 serves the operating system at 32768 Hz, channel 1 serves device drivers at 1 kHz, and channels 2 and 3 are general purpose at 1 MHz. The logic of all four channels is identical.

Each channel has its own 0x40-byte window, at 0x000, 0x040, 0x080 and 0x0C0. The registers in a window are:

- Three command strobes: reset at +0x00, enable at +0x04 and disable at +0x08. Any write to one of them acts, whatever the data.
- A mode register at +0x0C.
- A read-only status word at +0x10.
- A read-only current count at +0x14.
- A read/write terminal count at +0x18.
- An interrupt-enable register at +0x1C.
- An interrupt-acknowledge register at +0x20.

A single shared register at 0x100 holds a clock-request bit, which is driven out of the block.

Each channel is a two-state machine:

- **CH_IDLE** (state code 1): ticks are ignored.
- **CH_ACTIVE** (state code 2): each tick adds one to the count.

The transitions are:

- **T_START**: an enable command moves IDLE to ACTIVE.
- **T_HALT**: a disable command moves ACTIVE to IDLE.
- **T_CLEAR**: a reset command moves any state to IDLE.
- **T_EXPIRE**: a tick that lands on the terminal count in one-shot mode moves ACTIVE to IDLE.
- **T_WRAP**: a tick that lands on the terminal count in continuous mode keeps the channel ACTIVE and reloads the count to 0.

Both T_EXPIRE and T_WRAP set the pending flag. Each interrupt line is a level: it is the pending flag ANDed with the interrupt enable.

Top module: `quad_interval_timer`

## Requirements
- R1: After reset, every channel has count 0, terminal count 0xFFFFFFFF, continuous mode, interrupt disabled and nothing pending. Its status reads 0x01, every irq line is low, and the clock-request register and output are 0.
- R2: Channel n occupies addresses n*0x40 through n*0x40+0x20. A write or tick to one channel leaves the count, terminal count and status of the others unchanged. The terminal count at +0x18 reads back the value written.
- R3: Any write to +0x00 (reset), +0x04 (enable) or +0x08 (disable) performs its command whatever the write data, including 0.
- R4: While a channel is ACTIVE, each cycle with its tick input high adds 1 to its count. The new value is readable at +0x14 in the cycle after the tick.
- R5: While a channel is IDLE its ticks are ignored and the count holds.
- R6: In continuous mode (mode bit 0 = 0), a tick with count equal to the terminal count reloads the count to 0 and sets pending. The channel stays ACTIVE, so with terminal count T the event repeats every T+1 ticks.
- R7: In one-shot mode (mode bit 0 = 1), a tick with count equal to the terminal count sets pending, holds the count and returns the channel to IDLE.
- R8: Writing bit 0 of +0x1C sets or clears the interrupt enable. irq[n] is high exactly when pending and the interrupt enable are both set.
- R9: Writing exactly 0x80 to +0x20 clears pending, and any other value has no effect. If a terminal-count tick arrives in the same cycle as the acknowledge, pending stays set.
- R10: A reset command clears the count and pending and leaves the channel IDLE. It keeps the terminal count, the mode and the interrupt enable.
- R11: The status word at +0x10 is laid out as follows:
  - Bits [3:0] hold the state code: 1 for IDLE, 2 for ACTIVE.
  - Bit 4 is set while ACTIVE.
  - Bit 5 is set in one-shot mode.
  - Bit 6 is the interrupt enable.
  - Bit 7 is pending.
  - Bits [31:8] are 0.
- R12: These addresses read as 0:
  - the write-only registers (+0x00, +0x04, +0x08, +0x0C, +0x1C, +0x20);
  - unused offsets inside a channel window;
  - addresses that are not word-aligned;
  - every address above 0x100.
- R13: Bit 0 of the register at 0x100 is read/write and drives clk_req. The other bits of that register read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_en | input | 4 | Per-channel count-enable pulse |
| irq | output | 4 | Per-channel level interrupt |
| clk_req | output | 1 | Clock-request enable bit |

## Verification
A channel machine stuck in the wrong state shows at once in the status word's state code and bit 4. It also shows one cycle after the next tick, because a count that moves while IDLE or freezes while ACTIVE is visible at +0x14. A wrong terminal-count compare or reload shows on the irq line and in the count on the very tick that should wrap or expire. A wrong acknowledge decode or a wrong race priority shows on irq in the cycle after the write.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [3:0] {
        CH_IDLE   = 4'h1,
        CH_ACTIVE = 4'h2
    } ch_state_e;

    typedef struct packed {
        logic clear;
        logic start;
        logic halt;
        logic mode_we;
        logic tc_we;
        logic ie_we;
        logic ack_we;
    } ch_cmd_t;

    localparam int OFS_CLEAR  = 'h00;
    localparam int OFS_START  = 'h04;
    localparam int OFS_HALT   = 'h08;
    localparam int OFS_MODE   = 'h0C;
    localparam int OFS_STATUS = 'h10;
    localparam int OFS_COUNT  = 'h14;
    localparam int OFS_TERM   = 'h18;
    localparam int OFS_IE     = 'h1C;
    localparam int OFS_ACK    = 'h20;

    localparam int ACK_CODE   = 'h80;

    localparam int ST_BIT_RUN     = 4;
    localparam int ST_BIT_ONESHOT = 5;
    localparam int ST_BIT_IE      = 6;
    localparam int ST_BIT_PEND    = 7;

endpackage

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  ch_cmd_t       cmd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count,
    output logic [DW-1:0] term,
    output logic [DW-1:0] status,
    output logic          irq
);

    localparam logic [DW-1:0] TERM_RESET = '1;

    ch_state_e     state, state_nxt;
    logic          oneshot_q;
    logic          ie_q;
    logic          pend_q;
    logic [DW-1:0] count_q;
    logic [DW-1:0] term_q;

    logic tick_live;
    logic at_term;
    logic hit;

    assign tick_live = tick && (state == CH_ACTIVE) && !cmd.clear && !cmd.halt;
    assign at_term   = (count_q == term_q);
    assign hit       = tick_live && at_term;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            CH_IDLE: begin
                if (cmd.start && !cmd.clear) state_nxt = CH_ACTIVE;    // T_START
            end
            CH_ACTIVE: begin
                if (cmd.clear || cmd.halt)  state_nxt = CH_IDLE;       // T_CLEAR / T_HALT
                else if (hit && oneshot_q)  state_nxt = CH_IDLE;       // T_EXPIRE
            end
            default: state_nxt = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nxt;
    end

    // counter, configuration and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            term_q    <= TERM_RESET;
            oneshot_q <= 1'b0;
            ie_q      <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            if (cmd.mode_we) oneshot_q <= wdata[0];
            if (cmd.tc_we)   term_q    <= wdata;
            if (cmd.ie_we)   ie_q      <= wdata[0];

            if (cmd.clear) begin
                count_q <= '0;
            end else if (tick_live) begin
                if (at_term) begin
                    if (!oneshot_q) count_q <= '0;                     // T_WRAP
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end

            if (cmd.clear)
                pend_q <= 1'b0;
            else if (hit)
                pend_q <= 1'b1;
            else if (cmd.ack_we && (wdata == DW'(ACK_CODE)))
                pend_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        status                 = '0;
        status[3:0]            = state;
        status[ST_BIT_RUN]     = (state == CH_ACTIVE);
        status[ST_BIT_ONESHOT] = oneshot_q;
        status[ST_BIT_IE]      = ie_q;
        status[ST_BIT_PEND]    = pend_q;
        irq                    = pend_q && ie_q;
        count                  = count_q;
        term                   = term_q;
    end

endmodule

// File: rtl/timer_regdec.sv
module timer_regdec
    import timer_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DW        = 32,
    parameter int AW        = 9,
    parameter int CH_STRIDE = 64
) (
    input  logic                         bus_we,
    input  logic [AW-1:0]                bus_addr,
    input  logic [NUM_CH-1:0][DW-1:0]    ch_status,
    input  logic [NUM_CH-1:0][DW-1:0]    ch_count,
    input  logic [NUM_CH-1:0][DW-1:0]    ch_tc,
    input  logic                         clkreq_q,
    output ch_cmd_t [NUM_CH-1:0]         ch_cmd,
    output logic                         clkreq_we,
    output logic [DW-1:0]                bus_rdata
);

    localparam int OB        = $clog2(CH_STRIDE);
    localparam int CB        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CH_SPAN   = NUM_CH * CH_STRIDE;
    localparam logic [AW-1:0] CLKREQ_ADDR = AW'(CH_SPAN);

    logic          in_ch;
    logic [OB-1:0] off;
    logic [CB-1:0] idx;

    assign in_ch     = (bus_addr < AW'(CH_SPAN));
    assign off       = bus_addr[OB-1:0];
    assign idx       = bus_addr[OB +: CB];
    assign clkreq_we = bus_we && (bus_addr == CLKREQ_ADDR);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        logic sel;
        assign sel = bus_we && in_ch && (idx == CB'(g));
        assign ch_cmd[g].clear   = sel && (off == OB'(OFS_CLEAR));
        assign ch_cmd[g].start   = sel && (off == OB'(OFS_START));
        assign ch_cmd[g].halt    = sel && (off == OB'(OFS_HALT));
        assign ch_cmd[g].mode_we = sel && (off == OB'(OFS_MODE));
        assign ch_cmd[g].tc_we   = sel && (off == OB'(OFS_TERM));
        assign ch_cmd[g].ie_we   = sel && (off == OB'(OFS_IE));
        assign ch_cmd[g].ack_we  = sel && (off == OB'(OFS_ACK));
    end

    always_comb begin
        bus_rdata = '0;
        if (in_ch) begin
            if      (off == OB'(OFS_STATUS)) bus_rdata = ch_status[idx];
            else if (off == OB'(OFS_COUNT))  bus_rdata = ch_count[idx];
            else if (off == OB'(OFS_TERM))   bus_rdata = ch_tc[idx];
        end else if (bus_addr == CLKREQ_ADDR) begin
            bus_rdata[0] = clkreq_q;
        end
    end

endmodule

// File: rtl/quad_interval_timer.sv
module quad_interval_timer
    import timer_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DW        = 32,
    parameter int AW        = 9,
    parameter int CH_STRIDE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0] tick_en,
    output logic [NUM_CH-1:0] irq,
    output logic              clk_req
);

    ch_cmd_t [NUM_CH-1:0]      ch_cmd;
    logic [NUM_CH-1:0][DW-1:0] ch_status;
    logic [NUM_CH-1:0][DW-1:0] ch_count;
    logic [NUM_CH-1:0][DW-1:0] ch_tc;
    logic                      clkreq_q;
    logic                      clkreq_we;

    timer_regdec #(
        .NUM_CH(NUM_CH), .DW(DW), .AW(AW), .CH_STRIDE(CH_STRIDE)
    ) u_dec (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .ch_status (ch_status),
        .ch_count  (ch_count),
        .ch_tc     (ch_tc),
        .clkreq_q  (clkreq_q),
        .ch_cmd    (ch_cmd),
        .clkreq_we (clkreq_we),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        timer_channel #(.DW(DW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_en[g]),
            .cmd    (ch_cmd[g]),
            .wdata  (bus_wdata),
            .count  (ch_count[g]),
            .term   (ch_tc[g]),
            .status (ch_status[g]),
            .irq    (irq[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         clkreq_q <= 1'b0;
        else if (clkreq_we) clkreq_q <= bus_wdata[0];
    end

    assign clk_req = clkreq_q;

endmodule

// File: rtl/timer_checker.sv
module timer_checker
    import timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 32,
    parameter int AW     = 9
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [AW-1:0]             bus_addr,
    input logic [DW-1:0]             bus_wdata,
    input logic [DW-1:0]             bus_rdata,
    input logic [NUM_CH-1:0]         tick_en,
    input logic [NUM_CH-1:0]         irq,
    input ch_cmd_t [NUM_CH-1:0]      ch_cmd,
    input logic [NUM_CH-1:0][DW-1:0] ch_status,
    input logic [NUM_CH-1:0][DW-1:0] ch_count,
    input logic [NUM_CH-1:0][DW-1:0] ch_tc
);

    // R12: misaligned addresses return zero
    p_misaligned_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R8
        p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] == (ch_status[g][ST_BIT_PEND] && ch_status[g][ST_BIT_IE]));

        // R11
        p_state_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_status[g][3:0] == 4'h1) || (ch_status[g][3:0] == 4'h2));

        // R5
        p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_status[g][3:0] == 4'h1 && !ch_cmd[g].clear) |=> $stable(ch_count[g]));

        // R7
        p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_status[g][3:0] == 4'h2 && ch_status[g][ST_BIT_ONESHOT] && tick_en[g]
             && ch_count[g] == ch_tc[g] && !ch_cmd[g].clear && !ch_cmd[g].halt
             && !ch_cmd[g].mode_we && !ch_cmd[g].tc_we)
            |=> (ch_status[g][3:0] == 4'h1 && ch_status[g][ST_BIT_PEND]));

        // R9
        p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_cmd[g].ack_we && bus_wdata == DW'(ACK_CODE)
             && !(tick_en[g] && ch_status[g][3:0] == 4'h2 && ch_count[g] == ch_tc[g]))
            |=> !ch_status[g][ST_BIT_PEND]);
    end

endmodule

bind quad_interval_timer timer_checker #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tick_en   (tick_en),
    .irq       (irq),
    .ch_cmd    (ch_cmd),
    .ch_status (ch_status),
    .ch_count  (ch_count),
    .ch_tc     (ch_tc)
);

// File: tb/quad_interval_timer_test.sv
`timescale 1ns/1ps
module quad_interval_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_en = '0;
    logic [3:0]  irq;
    logic        clk_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam int R_CLR = 'h00, R_EN = 'h04, R_DIS = 'h08, R_MODE = 'h0C,
                   R_STAT = 'h10, R_CNT = 'h14, R_TC = 'h18, R_IE = 'h1C, R_ACK = 'h20;

    quad_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .irq(irq), .clk_req(clk_req)
    );

    always #5 clk = ~clk;

    function automatic logic [8:0] ra(int ch, int off);
        return 9'(ch * 64 + off);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(logic [8:0] a, logic [31:0] d, int ch);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d; tick_en[ch] = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en[ch] = 1'b0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(int ch, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en[ch] = 1'b1;
            @(negedge clk); tick_en[ch] = 1'b0;
        end
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin
            rd(ra(c, R_STAT), d); chk("R1 status", d, 32'h01);
            rd(ra(c, R_CNT), d);  chk("R1 count", d, 32'h0);
            rd(ra(c, R_TC), d);   chk("R1 term", d, 32'hFFFF_FFFF);
        end
        chk("R1 irq", {28'h0, irq}, 32'h0);
        chk("R1 clk_req", {31'h0, clk_req}, 32'h0);
        rd(9'h100, d); chk("R1 clkreq reg", d, 32'h0);
    endtask

    task automatic t_enable_count();
        logic [31:0] d;
        wr(ra(0, R_EN), 32'h0);
        rd(ra(0, R_STAT), d); chk("R3 enable with zero data", d, 32'h12);
        ticks(0, 5);
        rd(ra(0, R_CNT), d);  chk("R4 five ticks", d, 32'd5);
        wr(ra(0, R_DIS), 32'h0);
        rd(ra(0, R_STAT), d); chk("R3 disable with zero data", d, 32'h01);
        ticks(0, 3);
        rd(ra(0, R_CNT), d);  chk("R5 idle ticks ignored", d, 32'd5);
        rd(ra(1, R_CNT), d);  chk("R2 other channel untouched", d, 32'd0);
        wr(ra(0, R_EN), 32'h1234_5678);
        ticks(0, 2);
        rd(ra(0, R_CNT), d);  chk("R4 resume counting", d, 32'd7);
        wr(ra(0, R_DIS), 32'hFFFF_FFFF);
    endtask

    task automatic t_continuous();
        logic [31:0] d;
        wr(ra(1, R_TC), 32'd3);
        wr(ra(1, R_IE), 32'd1);
        wr(ra(1, R_EN), 32'd0);
        rd(ra(1, R_TC), d);   chk("R2 term readback", d, 32'd3);
        ticks(1, 3);
        rd(ra(1, R_CNT), d);  chk("R6 count at terminal", d, 32'd3);
        chk("R6 no irq before wrap", {31'h0, irq[1]}, 32'h0);
        ticks(1, 1);
        rd(ra(1, R_CNT), d);  chk("R6 reload to zero", d, 32'd0);
        chk("R8 irq on wrap", {31'h0, irq[1]}, 32'h1);
        rd(ra(1, R_STAT), d); chk("R11 active pending ie", d, 32'hD2);
        wr(ra(1, R_ACK), 32'h01);
        chk("R9 wrong ack value ignored", {31'h0, irq[1]}, 32'h1);
        wr(ra(1, R_ACK), 32'h80);
        chk("R9 ack clears", {31'h0, irq[1]}, 32'h0);
        rd(ra(1, R_STAT), d); chk("R11 pending cleared", d, 32'h52);
        ticks(1, 3);
        chk("R6 no early repeat", {31'h0, irq[1]}, 32'h0);
        ticks(1, 1);
        chk("R6 repeat after T+1", {31'h0, irq[1]}, 32'h1);
        wr(ra(1, R_DIS), 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] d;
        wr(ra(2, R_MODE), 32'd1);
        wr(ra(2, R_TC), 32'd2);
        wr(ra(2, R_IE), 32'd1);
        wr(ra(2, R_EN), 32'd0);
        rd(ra(2, R_STAT), d); chk("R11 oneshot active", d, 32'h72);
        ticks(2, 2);
        chk("R7 no irq before terminal", {31'h0, irq[2]}, 32'h0);
        ticks(2, 1);
        rd(ra(2, R_CNT), d);  chk("R7 count held", d, 32'd2);
        rd(ra(2, R_STAT), d); chk("R7 idle with pending", d, 32'hE1);
        chk("R7 irq", {31'h0, irq[2]}, 32'h1);
        ticks(2, 3);
        rd(ra(2, R_CNT), d);  chk("R5 stopped after expire", d, 32'd2);
    endtask

    task automatic t_reset_cmd();
        logic [31:0] d;
        wr(ra(2, R_CLR), 32'hDEAD_BEEF);
        rd(ra(2, R_CNT), d);  chk("R10 count cleared", d, 32'd0);
        rd(ra(2, R_STAT), d); chk("R10 mode ie kept pending cleared", d, 32'h61);
        rd(ra(2, R_TC), d);   chk("R10 term kept", d, 32'd2);
        chk("R10 irq low", {31'h0, irq[2]}, 32'h0);
    endtask

    task automatic t_ie_gate();
        logic [31:0] d;
        wr(ra(3, R_TC), 32'd0);
        wr(ra(3, R_EN), 32'd0);
        ticks(3, 1);
        rd(ra(3, R_STAT), d); chk("R8 pending without ie", d, 32'h92);
        chk("R8 irq masked", {31'h0, irq[3]}, 32'h0);
        wr(ra(3, R_IE), 32'd1);
        chk("R8 irq unmasked", {31'h0, irq[3]}, 32'h1);
        wr(ra(3, R_IE), 32'd0);
        chk("R8 irq masked again", {31'h0, irq[3]}, 32'h0);
    endtask

    task automatic t_ack_race();
        wr(ra(3, R_IE), 32'd1);
        wr_tick(ra(3, R_ACK), 32'h80, 3);
        chk("R9 event beats ack", {31'h0, irq[3]}, 32'h1);
        wr(ra(3, R_ACK), 32'h80);
        chk("R9 ack alone clears", {31'h0, irq[3]}, 32'h0);
        wr(ra(3, R_DIS), 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(ra(1, R_IE), d);   chk("R12 write-only reads zero", d, 32'h0);
        rd(ra(1, R_MODE), d); chk("R12 mode reads zero", d, 32'h0);
        rd(ra(0, 'h24), d);   chk("R12 unused offset", d, 32'h0);
        rd(ra(1, 'h3C), d);   chk("R12 window end", d, 32'h0);
        rd(ra(1, 'h19), d);   chk("R12 misaligned", d, 32'h0);
        rd(9'h104, d);        chk("R12 above shared", d, 32'h0);
        rd(9'h1FC, d);        chk("R12 top of space", d, 32'h0);
    endtask

    task automatic t_clkreq();
        logic [31:0] d;
        wr(9'h100, 32'hFFFF_FFFF);
        rd(9'h100, d); chk("R13 set", d, 32'h1);
        chk("R13 output set", {31'h0, clk_req}, 32'h1);
        wr(9'h100, 32'hFFFF_FFFE);
        rd(9'h100, d); chk("R13 clear", d, 32'h0);
        chk("R13 output clear", {31'h0, clk_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_enable_count();
        t_continuous();
        t_oneshot();
        t_reset_cmd();
        t_ie_gate();
        t_ack_race();
        t_unmapped();
        t_clkreq();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule